// File: doc/BRIEF.md
# Converter Serial Result Readout Port

This block is the serial output stage of a sampling converter. Each conversion result arrives as a parallel word with a one-cycle valid strobe. The block latches it into a shift register and sends it out most significant bit first on one data line. The word can be sent as straight binary or as two's complement. Two's complement is formed by flipping the top bit when the word is latched.

The port has two clocking modes. In slave mode a host drives the serial clock while chip select and read are both low. A select input chooses whether the data advances on the rising or the falling clock edge. A result that lands while a slave read is part-way through replaces the old word and raises a one-cycle read-error pulse.

In master mode the port makes its own serial clock by dividing the system clock. Each bit is held for one whole clock period, which starts with the low half. A frame sync with selectable polarity is active for the whole frame. All logic runs on the system clock, and the external serial clock is sampled as ordinary data.

Top module: `readout_port`

## Requirements
- R1: With `fmtTwos` low at load, the 16 bits read out equal the latched result unchanged.
- R2: With `fmtTwos` high at load, the bits read out equal the result with bit 15 inverted and bits 14..0 unchanged.
- R3: Bits leave MSB first. In slave mode with `invClk` low, each rising edge of `sclkIn` seen while enabled moves the next bit onto `sdo`, and falling edges have no effect.
- R4: In slave mode with `invClk` high, only falling edges of `sclkIn` advance the data, and rising edges have no effect.
- R5: The port is enabled only while `csN` and `rdN` are both low. In slave mode `sdoEn` follows that enable. When `sdoEn` is low, `sdo` is 0. `sclkIn` edges that occur while the port is disabled do not advance the data.
- R6: In master mode, once a new result is ready and the port is enabled, the port sends 16 serial clock periods of `DIV` system cycles each, low half first. `sdo` changes only at the start of a period and is stable while `sclkOut` is high.
- R7: In master mode `syncOut` is active for exactly the `16*DIV` cycles of the frame. Active means high when `invSync` is low and low when `invSync` is high.
- R8: In slave mode, a result latched after 1 to 15 bits of a read have advanced replaces the old word, restarts the read, and sets `rdError` high for exactly the one cycle after the load.
- R9: A result latched before any slave bit has advanced, or after all 16 bits have advanced, leaves `rdError` low.
- R10: A synchronous reset clears the shift register, both bit counters and `rdError`, so a read after reset returns zero.
- R11: Outside a master frame, `sclkOut` is 0, `syncOut` sits at its inactive level and `sdoEn` is 0 in master mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| resultIn | input | 16 | Conversion result word |
| resultValid | input | 1 | One-cycle strobe that latches `resultIn` |
| fmtTwos | input | 1 | 1 = two's complement coding, 0 = straight binary |
| masterMode | input | 1 | 1 = internal clock and sync, 0 = host-driven clock |
| invClk | input | 1 | Slave update edge: 0 = rising, 1 = falling |
| invSync | input | 1 | Sync polarity: 0 = active high, 1 = active low |
| csN | input | 1 | Chip select, active low; also gates `sclkIn` |
| rdN | input | 1 | Read enable, active low |
| sclkIn | input | 1 | Serial clock from the host in slave mode |
| sclkOut | output | 1 | Generated serial clock in master mode |
| syncOut | output | 1 | Frame sync |
| sdo | output | 1 | Serial data |
| sdoEn | output | 1 | Drive enable for `sdo`; low means the line floats |
| rdError | output | 1 | One-cycle pulse on an interrupted slave read |

## Verification
The bound checker watches the following on every cycle:
- `sdo` is driven only while chip select and read allow it.
- `sdo` is 0 whenever the drive enable is low.
- `sclkOut` never runs outside an active sync.
- `sdo` is steady across the high half of each master clock period.
- `rdError` lasts exactly one cycle and always follows a slave-mode load.

The bench scenarios cover what needs a whole read to observe:
- the data values under both codings and both slave clock edges;
- edges that are ignored while chip select is high;
- the frame length, the clock period count and the sync polarity in master mode;
- the error pulse when a read is cut off compared with a read that is complete or not yet started;
- the state left after a reset.

// File: rtl/readout_pkg.sv
package readout_pkg;

  // Strobes the control unit sends to the shift datapath.
  typedef struct packed {
    logic load;   // capture a new result, with coding applied
    logic shift;  // move the next bit to the top
  } dpStrobe_t;

endpackage

// File: rtl/readout_dp.sv
module readout_dp
  import readout_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  dpStrobe_t        strobe,
  input  logic [WIDTH-1:0] resultIn,
  input  logic             fmtTwos,
  output logic             msb
);

  logic [WIDTH-1:0] shiftReg;

  // Coding is applied once, at load: two's complement flips the top bit.
  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '0;
    end else if (strobe.load) begin
      shiftReg <= {resultIn[WIDTH-1] ^ fmtTwos, resultIn[WIDTH-2:0]};
    end else if (strobe.shift) begin
      shiftReg <= {shiftReg[WIDTH-2:0], 1'b0};
    end
  end

  assign msb = shiftReg[WIDTH-1];

endmodule

// File: rtl/readout_ctrl.sv
module readout_ctrl
  import readout_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int DIV   = 4
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      resultValid,
  input  logic      masterMode,
  input  logic      invClk,
  input  logic      invSync,
  input  logic      csN,
  input  logic      rdN,
  input  logic      sclkIn,
  output dpStrobe_t strobe,
  output logic      sclkOut,
  output logic      syncOut,
  output logic      sdoEn,
  output logic      rdError
);

  localparam int CNT_W = $clog2(WIDTH + 1);
  localparam int BIT_W = $clog2(WIDTH);
  localparam int DIV_W = $clog2(DIV);
  localparam logic [CNT_W-1:0] SLV_DONE = CNT_W'(WIDTH);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(WIDTH - 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV - 1);
  localparam logic [DIV_W-1:0] DIV_HALF = DIV_W'(DIV / 2);

  logic             portEn;
  logic             sclkPrev;
  logic             riseEdge;
  logic             fallEdge;
  logic             slvEdge;
  logic [CNT_W-1:0] slvCnt;
  logic             slvBusy;
  logic             slaveStep;
  logic             frameActive;
  logic             frameReady;
  logic [DIV_W-1:0] divCnt;
  logic [BIT_W-1:0] bitCnt;
  logic             masterRun;
  logic             masterStep;
  logic             startFrame;

  // Chip select and read together open the port and gate the host clock.
  always_comb begin
    portEn     = !csN && !rdN;
    riseEdge   = portEn && sclkIn && !sclkPrev;
    fallEdge   = portEn && !sclkIn && sclkPrev;
    slvEdge    = invClk ? fallEdge : riseEdge;
    slvBusy    = (slvCnt != '0) && (slvCnt != SLV_DONE);
    slaveStep  = !masterMode && slvEdge && (slvCnt != SLV_DONE) && !resultValid;
    masterRun  = masterMode && portEn && frameActive;
    masterStep = masterRun && (divCnt == DIV_LAST) && !resultValid;
    startFrame = masterMode && portEn && frameReady && !frameActive && !resultValid;
  end

  always_comb begin
    strobe.load  = resultValid;
    strobe.shift = slaveStep || masterStep;
    sclkOut      = masterRun && (divCnt >= DIV_HALF);
    syncOut      = masterRun ^ invSync;
    sdoEn        = masterMode ? masterRun : portEn;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sclkPrev    <= 1'b0;
      rdError     <= 1'b0;
      slvCnt      <= '0;
      frameActive <= 1'b0;
      frameReady  <= 1'b0;
      divCnt      <= '0;
      bitCnt      <= '0;
    end else begin
      sclkPrev <= sclkIn;
      rdError  <= resultValid && !masterMode && slvBusy;
      if (resultValid) begin
        // A new result restarts both readout paths.
        slvCnt      <= '0;
        frameReady  <= 1'b1;
        frameActive <= 1'b0;
        divCnt      <= '0;
        bitCnt      <= '0;
      end else begin
        if (slaveStep) begin
          slvCnt <= slvCnt + 1'b1;
        end
        if (startFrame) begin
          frameActive <= 1'b1;
          frameReady  <= 1'b0;
          divCnt      <= '0;
          bitCnt      <= '0;
        end else if (frameActive) begin
          if (!masterRun) begin
            frameActive <= 1'b0;
          end else if (divCnt == DIV_LAST) begin
            divCnt <= '0;
            bitCnt <= bitCnt + 1'b1;
            if (bitCnt == BIT_LAST) begin
              frameActive <= 1'b0;
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/readout_port.sv
module readout_port
  import readout_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int DIV   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] resultIn,
  input  logic             resultValid,
  input  logic             fmtTwos,
  input  logic             masterMode,
  input  logic             invClk,
  input  logic             invSync,
  input  logic             csN,
  input  logic             rdN,
  input  logic             sclkIn,
  output logic             sclkOut,
  output logic             syncOut,
  output logic             sdo,
  output logic             sdoEn,
  output logic             rdError
);

  dpStrobe_t strobe;
  logic      msb;

  readout_ctrl #(.WIDTH(WIDTH), .DIV(DIV)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .resultValid(resultValid),
    .masterMode (masterMode),
    .invClk     (invClk),
    .invSync    (invSync),
    .csN        (csN),
    .rdN        (rdN),
    .sclkIn     (sclkIn),
    .strobe     (strobe),
    .sclkOut    (sclkOut),
    .syncOut    (syncOut),
    .sdoEn      (sdoEn),
    .rdError    (rdError)
  );

  readout_dp #(.WIDTH(WIDTH)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .resultIn(resultIn),
    .fmtTwos (fmtTwos),
    .msb     (msb)
  );

  assign sdo = sdoEn & msb;

endmodule

// File: rtl/readout_port_chk.sv
module readout_port_chk (
  input logic clk,
  input logic rst,
  input logic resultValid,
  input logic masterMode,
  input logic invSync,
  input logic csN,
  input logic rdN,
  input logic sclkOut,
  input logic syncOut,
  input logic sdo,
  input logic sdoEn,
  input logic rdError
);

  p_en_gate_r5: assert property (@(posedge clk) disable iff (rst)
    sdoEn |-> (!csN && !rdN));

  p_sdo_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !sdoEn |-> (sdo == 1'b0));

  p_sclk_in_frame_r7: assert property (@(posedge clk) disable iff (rst)
    sclkOut |-> (syncOut != invSync));

  p_sclk_driven_r11: assert property (@(posedge clk) disable iff (rst)
    sclkOut |-> sdoEn);

  p_hold_high_r6: assert property (@(posedge clk) disable iff (rst)
    (sclkOut && $past(sclkOut)) |-> $stable(sdo));

  p_hold_rise_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(sclkOut) |-> $stable(sdo));

  p_err_single_r8: assert property (@(posedge clk) disable iff (rst)
    rdError |=> !rdError);

  p_err_cause_r8: assert property (@(posedge clk) disable iff (rst)
    rdError |-> ($past(resultValid) && !$past(masterMode)));

endmodule

bind readout_port readout_port_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .resultValid(resultValid),
  .masterMode (masterMode),
  .invSync    (invSync),
  .csN        (csN),
  .rdN        (rdN),
  .sclkOut    (sclkOut),
  .syncOut    (syncOut),
  .sdo        (sdo),
  .sdoEn      (sdoEn),
  .rdError    (rdError)
);

// File: tb/sim_readout_port.sv
module sim_readout_port;

  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;

  // {data, fmtTwos, invClk}
  localparam logic [17:0] VEC [0:5] = '{
    {16'hA5C3, 1'b0, 1'b0},
    {16'h0001, 1'b1, 1'b0},
    {16'hFFFF, 1'b0, 1'b1},
    {16'h8000, 1'b1, 1'b1},
    {16'h1234, 1'b0, 1'b0},
    {16'h7F0E, 1'b1, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] resultIn = '0;
  logic        resultValid = 1'b0;
  logic        fmtTwos = 1'b0;
  logic        masterMode = 1'b0;
  logic        invClk = 1'b0;
  logic        invSync = 1'b0;
  logic        csN = 1'b1;
  logic        rdN = 1'b1;
  logic        sclkIn = 1'b0;
  logic        sclkOut, syncOut, sdo, sdoEn, rdError;

  int checkCount = 0;
  int failCount  = 0;

  readout_port #(.WIDTH(16), .DIV(DIV)) u0 (
    .clk(clk), .rst(rst), .resultIn(resultIn), .resultValid(resultValid),
    .fmtTwos(fmtTwos), .masterMode(masterMode), .invClk(invClk),
    .invSync(invSync), .csN(csN), .rdN(rdN), .sclkIn(sclkIn),
    .sclkOut(sclkOut), .syncOut(syncOut), .sdo(sdo), .sdoEn(sdoEn),
    .rdError(rdError)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic loadResult(input logic [15:0] d, input logic f);
    @(negedge clk);
    resultIn = d; fmtTwos = f; resultValid = 1'b1;
    @(negedge clk);
    resultValid = 1'b0;
  endtask

  task automatic setIdle(input logic inv);
    csN = 1'b1; rdN = 1'b1; invClk = inv; sclkIn = inv;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic enablePort();
    csN = 1'b0; rdN = 1'b0;
    #1;
  endtask

  task automatic slaveBits(input int n, inout logic [15:0] acc);
    for (int i = 0; i < n; i++) begin
      acc = {acc[14:0], sdo};
      sclkIn = !invClk;
      @(negedge clk);
      sclkIn = invClk;
      @(negedge clk);
    end
  endtask

  task automatic masterFrame(input logic [15:0] d, input logic f, input logic invS,
                             input logic [15:0] exp);
    int syncCycles = 0;
    int rises = 0;
    int moves = 0;
    logic prevSclk = 1'b0;
    logic prevSdo = 1'b0;
    logic [15:0] word = '0;
    setIdle(1'b0);
    masterMode = 1'b1; invSync = invS;
    loadResult(d, f);
    check("R11 sdoEn idle before frame", {31'd0, sdoEn}, 32'd0);
    check("R11 sync inactive before frame", {31'd0, syncOut}, {31'd0, invS});
    enablePort();
    for (int c = 0; c < 16 * DIV + 20; c++) begin
      @(negedge clk);
      if (syncOut != invS) syncCycles++;
      if (sclkOut && !prevSclk) begin
        rises++;
        word = {word[14:0], sdo};
      end
      if (sclkOut && (sdo != prevSdo)) moves++;
      prevSclk = sclkOut;
      prevSdo = sdo;
    end
    check("R7 sync active length", syncCycles, 16 * DIV);
    check("R6 serial clock periods", rises, 16);
    check("R6 master data word", {16'd0, word}, {16'd0, exp});
    check("R6 data held while clock high", moves, 0);
    check("R11 clock idle after frame", {31'd0, sclkOut}, 32'd0);
    check("R11 sdoEn low after frame", {31'd0, sdoEn}, 32'd0);
    check("R11 sync inactive after frame", {31'd0, syncOut}, {31'd0, invS});
    masterMode = 1'b0; invSync = 1'b0;
    setIdle(1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    logic [15:0] acc;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R10 reset rdError", {31'd0, rdError}, 32'd0);
    check("R11 reset sclkOut", {31'd0, sclkOut}, 32'd0);
    check("R5 reset sdoEn", {31'd0, sdoEn}, 32'd0);
    check("R7 reset sync inactive", {31'd0, syncOut}, 32'd0);

    // Table walk: R1/R2 coding, R3/R4 edge selection.
    for (int v = 0; v < 6; v++) begin
      logic [15:0] d;
      logic f, inv;
      logic [15:0] exp;
      {d, f, inv} = VEC[v];
      exp = f ? (d ^ 16'h8000) : d;
      setIdle(inv);
      loadResult(d, f);
      enablePort();
      acc = '0;
      slaveBits(16, acc);
      check(f ? (inv ? "R2 R4 vector" : "R2 R3 vector") : (inv ? "R1 R4 vector" : "R1 R3 vector"),
            {16'd0, acc}, {16'd0, exp});
    end

    // R4: a rising edge does not advance the data when falling edges are selected.
    setIdle(1'b1);
    loadResult(16'h4000, 1'b0);
    sclkIn = 1'b0;
    @(negedge clk); @(negedge clk);
    enablePort();
    check("R4 first bit", {31'd0, sdo}, 32'd0);
    sclkIn = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R4 rising edge ignored", {31'd0, sdo}, 32'd0);
    sclkIn = 1'b0;
    @(negedge clk);
    check("R4 falling edge advances", {31'd0, sdo}, 32'd1);

    // R3: a falling edge does not advance the data when rising edges are selected.
    setIdle(1'b0);
    loadResult(16'h4000, 1'b0);
    sclkIn = 1'b1;
    @(negedge clk); @(negedge clk);
    enablePort();
    sclkIn = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R3 falling edge ignored", {31'd0, sdo}, 32'd0);

    // R5: gating by chip select and read.
    setIdle(1'b0);
    loadResult(16'hC3A5, 1'b0);
    csN = 1'b1; rdN = 1'b0;
    #1;
    check("R5 cs high disables sdoEn", {31'd0, sdoEn}, 32'd0);
    check("R5 sdo low when disabled", {31'd0, sdo}, 32'd0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); sclkIn = 1'b1;
      @(negedge clk); sclkIn = 1'b0;
    end
    csN = 1'b0; rdN = 1'b1;
    #1;
    check("R5 rd high disables sdoEn", {31'd0, sdoEn}, 32'd0);
    @(negedge clk);
    enablePort();
    check("R5 enabled", {31'd0, sdoEn}, 32'd1);
    acc = '0;
    slaveBits(16, acc);
    check("R5 gated edges ignored", {16'd0, acc}, 32'h0000C3A5);

    // R8 / R9: an interrupted read, then complete and unstarted reads.
    setIdle(1'b0);
    loadResult(16'h1111, 1'b0);
    enablePort();
    acc = '0;
    slaveBits(5, acc);
    loadResult(16'h2222, 1'b0);
    check("R8 error pulse high", {31'd0, rdError}, 32'd1);
    @(negedge clk);
    check("R8 error pulse one cycle", {31'd0, rdError}, 32'd0);
    acc = '0;
    slaveBits(16, acc);
    check("R8 new data replaces old", {16'd0, acc}, 32'h00002222);
    loadResult(16'h3333, 1'b0);
    check("R9 no error after full read", {31'd0, rdError}, 32'd0);
    loadResult(16'h4444, 1'b0);
    check("R9 no error before read start", {31'd0, rdError}, 32'd0);

    // R10: reset clears the shift register and error.
    setIdle(1'b0);
    loadResult(16'hBEEF, 1'b0);
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R10 rdError cleared", {31'd0, rdError}, 32'd0);
    enablePort();
    acc = 16'hFFFF;
    slaveBits(16, acc);
    check("R10 shift register cleared", {16'd0, acc}, 32'd0);

    // R6 / R7 / R11: master frames with both sync polarities.
    masterFrame(16'hB38D, 1'b0, 1'b0, 16'hB38D);
    masterFrame(16'h0F5A, 1'b1, 1'b1, 16'h8F5A);

    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

endmodule